// File: doc/BRIEF.md
# Staged Root Clock Divider Controller

This block sits between a simple register bus and a root clock source. Software programs a staged copy of the divider setup: source select, counter mode, half-integer divide field, and the M, N and D values. Nothing reaches the running clock until software sets the update bit in the command register. The block then captures the staged values as one snapshot and passes a request into the root clock domain. There the snapshot is applied at a period boundary, while the generated clock is low. The hardware clears the update bit once the handshake has come back. Software polls the bit to learn that the change has completed.

The generated clock comes from a half-integer divider that counts half-periods of the root clock, so ratios such as 1.5, 2.5 and 3.5 come out exact. A command bit enables the root. The block reports a root-off status, which is also available on a port. The M, N and D values are only stored and forwarded here. Software encodes N as the inverse of (N - M) and D as the inverse of N, each within the M/N/D width. The counter that consumes these values lives elsewhere.

Top module: `clkroot_ctrl`

## Requirements
- R1: Staged registers sit at byte offsets 0x4 (setup), 0x8 (M), 0xC (N) and 0x10 (D), with the command register at 0x0. Setup holds the divide field in bits 7:0, masked to HIDW bits, the source select in bits 10:8 and the mode in bits 13:12. M, N and D are masked to MNDW bits. Every other bit reads 0.
- R2: A write to a staged register sets its dirty flag in the command register: bit 4 for setup, bit 5 for N, bit 6 for M and bit 7 for D.
- R3: The live outputs keep their values until an update is requested. Writing 1 to command bit 0 sets the update bit, which reads back 1 on the next bus cycle.
- R4: After an update request the hardware applies the snapshot to the live outputs and then clears command bit 0 by itself, within a bounded time. This holds even while the root is disabled.
- R5: When an update completes, the dirty flags clear, except for flags of registers that were written while that update was pending.
- R6: Staged writes made while an update is pending do not reach the live outputs until a later update.
- R7: Command bit 31 and the root_off port read 1 when the root enable is 0, or when the source picked by the live select is not running. Otherwise they read 0.
- R8: The output clock period is (div+1) half-periods of the root clock for div of 1 or more, and one root period when div is 0 (bypass). The high time is floor(period/2) half-periods.
- R9: A new setup takes effect only at a period boundary, while the output clock is low.
- R10: With the root enable at 0, the output clock stops low at the next period boundary. It resumes with the live ratio when the enable returns to 1.
- R11: Command bit 1 is the root enable. It is written and read back at that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| root_clk | input | 1 | Root clock source |
| root_rst | input | 1 | Synchronous active-high reset, root domain |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_run | input | 8 | Running flag of each selectable source |
| live_div | output | HIDW | Live half-integer divide field |
| live_sel | output | 3 | Live source select |
| live_mode | output | 2 | Live counter mode (2 = dual-edge) |
| live_m | output | MNDW | Live M value |
| live_n | output | MNDW | Live encoded N value |
| live_d | output | MNDW | Live encoded D value |
| root_off | output | 1 | Root-off status |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong snapshot or a lost request appears on the live ports as soon as the update bit reads 0. The stale or premature values are then visible right away, and a stuck handshake leaves the update bit at 1 past the polling limit. A wrong phase counter or half-period decode shows in the first full output period measured after the commit, either in the period or in the high time. A sweep over every divide field catches odd and even ratios alike. Mistakes in dirty tracking or root-off appear on the next read of the command register.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    // Register byte offsets
    localparam logic [4:0] OFS_CMD = 5'h00;
    localparam logic [4:0] OFS_CFG = 5'h04;
    localparam logic [4:0] OFS_M   = 5'h08;
    localparam logic [4:0] OFS_N   = 5'h0C;
    localparam logic [4:0] OFS_D   = 5'h10;

    // Command register bit positions
    localparam int CMD_UPD      = 0;
    localparam int CMD_EN       = 1;
    localparam int CMD_DIRTY_LO = 4;
    localparam int CMD_OFF      = 31;

    localparam int DIV_FIELD_W = 8;

    // Index of each dirty flag, offset from CMD_DIRTY_LO
    typedef enum logic [1:0] {
        DF_CFG = 2'd0,
        DF_N   = 2'd1,
        DF_M   = 2'd2,
        DF_D   = 2'd3
    } dirty_idx_e;

    typedef struct packed {
        logic [1:0]             mode;
        logic [2:0]             sel;
        logic [DIV_FIELD_W-1:0] div;
    } rc_cfg_t;

    // Output period in root half-periods; field 0 bypasses (one root period)
    function automatic logic [DIV_FIELD_W:0] half_periods(input logic [DIV_FIELD_W-1:0] div);
        return (div == '0) ? (DIV_FIELD_W+1)'(2) : {1'b0, div} + (DIV_FIELD_W+1)'(1);
    endfunction

endpackage

// File: rtl/clkroot_sync.sv
module clkroot_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/clkroot_regs.sv
module clkroot_regs
    import clkroot_pkg::*;
#(
    parameter int HIDW = 5,
    parameter int MNDW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [4:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic            ack_s,
    input  logic            root_off,
    output logic            upd_req,
    output logic            root_en,
    output rc_cfg_t         snap_cfg,
    output logic [MNDW-1:0] snap_m,
    output logic [MNDW-1:0] snap_n,
    output logic [MNDW-1:0] snap_d
);
    localparam logic [DIV_FIELD_W-1:0] DIV_MASK = DIV_FIELD_W'((1 << HIDW) - 1);

    rc_cfg_t         stg_cfg;
    logic [MNDW-1:0] stg_m, stg_n, stg_d;
    logic [3:0]      dirty, dirty_late, wr_hit;
    logic            busy, start, cmd_wr, done;

    assign busy   = upd_req | ack_s;
    assign cmd_wr = bus_wr && (bus_addr == OFS_CMD);
    assign start  = cmd_wr && bus_wdata[CMD_UPD] && !busy;
    assign done   = upd_req && ack_s;

    always_comb begin
        wr_hit         = '0;
        wr_hit[DF_CFG] = bus_wr && (bus_addr == OFS_CFG);
        wr_hit[DF_N]   = bus_wr && (bus_addr == OFS_N);
        wr_hit[DF_M]   = bus_wr && (bus_addr == OFS_M);
        wr_hit[DF_D]   = bus_wr && (bus_addr == OFS_D);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_cfg    <= '0;
            stg_m      <= '0;
            stg_n      <= '0;
            stg_d      <= '0;
            snap_cfg   <= '0;
            snap_m     <= '0;
            snap_n     <= '0;
            snap_d     <= '0;
            dirty      <= '0;
            dirty_late <= '0;
            upd_req    <= 1'b0;
            root_en    <= 1'b0;
        end else begin
            if (wr_hit[DF_CFG]) begin
                stg_cfg.mode <= bus_wdata[13:12];
                stg_cfg.sel  <= bus_wdata[10:8];
                stg_cfg.div  <= bus_wdata[7:0] & DIV_MASK;
            end
            if (wr_hit[DF_M]) stg_m <= bus_wdata[MNDW-1:0];
            if (wr_hit[DF_N]) stg_n <= bus_wdata[MNDW-1:0];
            if (wr_hit[DF_D]) stg_d <= bus_wdata[MNDW-1:0];
            if (cmd_wr) root_en <= bus_wdata[CMD_EN];

            if (start) begin
                upd_req    <= 1'b1;
                snap_cfg   <= stg_cfg;
                snap_m     <= stg_m;
                snap_n     <= stg_n;
                snap_d     <= stg_d;
                dirty_late <= '0;
                dirty      <= dirty | wr_hit;
            end else if (done) begin
                upd_req    <= 1'b0;
                dirty      <= dirty_late | wr_hit;
                dirty_late <= '0;
            end else begin
                dirty <= dirty | wr_hit;
                if (upd_req) dirty_late <= dirty_late | wr_hit;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CMD: bus_rdata = {root_off, 23'b0, dirty, 2'b0, root_en, busy};
            OFS_CFG: bus_rdata = {18'b0, stg_cfg.mode, 1'b0, stg_cfg.sel, stg_cfg.div};
            OFS_M:   bus_rdata = 32'(stg_m);
            OFS_N:   bus_rdata = 32'(stg_n);
            OFS_D:   bus_rdata = 32'(stg_d);
            default: bus_rdata = '0;
        endcase
    end

    AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CFG) |=> dirty[DF_CFG]); // R2

    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (rst)
        (upd_req && $past(upd_req)) |-> $stable(snap_cfg)); // R6

    AST_UPDATE_CLEARS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_req) |-> ack_s); // R4
endmodule

// File: rtl/clkroot_hidiv.sv
module clkroot_hidiv
    import clkroot_pkg::*;
#(
    parameter int HIDW = 5,
    parameter int MNDW = 8
) (
    input  logic            root_clk,
    input  logic            root_rst,
    input  logic            req_s,
    input  logic            en_s,
    input  rc_cfg_t         snap_cfg,
    input  logic [MNDW-1:0] snap_m,
    input  logic [MNDW-1:0] snap_n,
    input  logic [MNDW-1:0] snap_d,
    output logic            ack,
    output rc_cfg_t         live_cfg,
    output logic [MNDW-1:0] live_m,
    output logic [MNDW-1:0] live_n,
    output logic [MNDW-1:0] live_d,
    output logic            clk_out
);
    localparam int PW = HIDW + 2;

    logic [PW-1:0] ph_q, d_cur, d_new, d_use;
    logic          p_q, n_q, n_pend, at_zero, commit, hold;

    function automatic logic [PW-1:0] wrap(input logic [PW-1:0] v, input logic [PW-1:0] d);
        return (v >= d) ? v - d : v;
    endfunction

    function automatic logic edge_hit(input logic [PW-1:0] ph, input logic [PW-1:0] d);
        return (ph == '0) || (ph == (d >> 1));
    endfunction

    assign d_cur   = PW'(half_periods(live_cfg.div));
    assign d_new   = PW'(half_periods(snap_cfg.div));
    assign at_zero = (ph_q == '0);
    assign commit  = at_zero && req_s && !ack;
    assign d_use   = commit ? d_new : d_cur;
    assign hold    = at_zero && !en_s;

    always_ff @(posedge root_clk) begin
        if (root_rst) begin
            ph_q     <= '0;
            p_q      <= 1'b0;
            n_pend   <= 1'b0;
            ack      <= 1'b0;
            live_cfg <= '0;
            live_m   <= '0;
            live_n   <= '0;
            live_d   <= '0;
        end else begin
            if (commit) begin
                live_cfg <= snap_cfg;
                live_m   <= snap_m;
                live_n   <= snap_n;
                live_d   <= snap_d;
                ack      <= 1'b1;
            end else if (!req_s) begin
                ack <= 1'b0;
            end

            if (hold) begin
                n_pend <= 1'b0;
            end else begin
                p_q    <= p_q ^ edge_hit(ph_q, d_use);
                n_pend <= edge_hit(wrap(ph_q + PW'(1), d_use), d_use);
                ph_q   <= wrap(ph_q + PW'(2), d_use);
            end
        end
    end

    always_ff @(negedge root_clk) begin
        if (root_rst) n_q <= 1'b0;
        else          n_q <= n_q ^ n_pend;
    end

    assign clk_out = p_q ^ n_q;

    AST_COMMIT_WHILE_LOW: assert property (@(posedge root_clk) disable iff (root_rst)
        commit |-> !clk_out); // R9

    AST_PHASE_IN_RANGE: assert property (@(posedge root_clk) disable iff (root_rst)
        ph_q < d_cur); // R8

    AST_LIVE_HELD_NO_REQ: assert property (@(posedge root_clk) disable iff (root_rst)
        !req_s |=> $stable(live_cfg)); // R3
endmodule

// File: rtl/clkroot_ctrl.sv
module clkroot_ctrl
    import clkroot_pkg::*;
#(
    parameter int HIDW = 5,
    parameter int MNDW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            root_clk,
    input  logic            root_rst,
    input  logic            bus_wr,
    input  logic [4:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [7:0]      src_run,
    output logic [HIDW-1:0] live_div,
    output logic [2:0]      live_sel,
    output logic [1:0]      live_mode,
    output logic [MNDW-1:0] live_m,
    output logic [MNDW-1:0] live_n,
    output logic [MNDW-1:0] live_d,
    output logic            root_off,
    output logic            clk_out
);
    rc_cfg_t         snap_cfg, live_cfg;
    logic [MNDW-1:0] snap_m, snap_n, snap_d;
    logic            upd_req, root_en, ack_root, ack_s;
    logic [1:0]      root_side;

    clkroot_regs #(.HIDW(HIDW), .MNDW(MNDW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ack_s     (ack_s),
        .root_off  (root_off),
        .upd_req   (upd_req),
        .root_en   (root_en),
        .snap_cfg  (snap_cfg),
        .snap_m    (snap_m),
        .snap_n    (snap_n),
        .snap_d    (snap_d)
    );

    clkroot_sync #(.W(2), .STAGES(2)) to_root_i (
        .clk  (root_clk),
        .rst  (root_rst),
        .din  ({root_en, upd_req}),
        .dout (root_side)
    );

    clkroot_sync #(.W(1), .STAGES(2)) to_bus_i (
        .clk  (clk),
        .rst  (rst),
        .din  (ack_root),
        .dout (ack_s)
    );

    clkroot_hidiv #(.HIDW(HIDW), .MNDW(MNDW)) div_i (
        .root_clk (root_clk),
        .root_rst (root_rst),
        .req_s    (root_side[0]),
        .en_s     (root_side[1]),
        .snap_cfg (snap_cfg),
        .snap_m   (snap_m),
        .snap_n   (snap_n),
        .snap_d   (snap_d),
        .ack      (ack_root),
        .live_cfg (live_cfg),
        .live_m   (live_m),
        .live_n   (live_n),
        .live_d   (live_d),
        .clk_out  (clk_out)
    );

    assign live_div  = live_cfg.div[HIDW-1:0];
    assign live_sel  = live_cfg.sel;
    assign live_mode = live_cfg.mode;
    assign root_off  = !root_en || !src_run[live_cfg.sel];

    AST_ROOT_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CMD && !bus_wdata[CMD_EN]) |=> root_off); // R7
endmodule

// File: tb/clkroot_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkroot_ctrl_tb_top;
    localparam int HIDW = 5;
    localparam int MNDW = 8;
    localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_M = 5'h08, A_N = 5'h0C, A_D = 5'h10;
    localparam real HALF = 5.0;

    logic clk = 1'b0, root_clk = 1'b0, rst = 1'b1, root_rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0] src_run = 8'hFF;
    logic [HIDW-1:0] live_div;
    logic [2:0] live_sel;
    logic [1:0] live_mode;
    logic [MNDW-1:0] live_m, live_n, live_d;
    logic root_off, clk_out;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;
    initial begin #1.3; forever #5 root_clk = ~root_clk; end

    clkroot_ctrl #(.HIDW(HIDW), .MNDW(MNDW)) dut_i (
        .clk(clk), .rst(rst), .root_clk(root_clk), .root_rst(root_rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_run(src_run), .live_div(live_div), .live_sel(live_sel), .live_mode(live_mode),
        .live_m(live_m), .live_n(live_n), .live_d(live_d), .root_off(root_off), .clk_out(clk_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_t(input string req, input real act, input real exp);
        n_chk++;
        if (act - exp > 0.01 || exp - act > 0.01) begin
            n_fail++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        do begin rd(A_CMD, v); n++; end while (v[0] && n < 400);
        chk(req, {31'b0, v[0]}, 32'h0);
    endtask

    task automatic measure(output real per, output real hi);
        real t0, t1, t2;
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        per = t2 - t0;
        hi = t1 - t0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        real per, hi;
        int hcnt;
        repeat (10) @(posedge root_clk);
        @(negedge clk); rst = 1'b0; root_rst = 1'b0;

        // reset state
        rd(A_CMD, v);  chk("R7 R11 reset cmd", v, 32'h8000_0000);
        rd(A_CFG, v);  chk("R1 reset cfg", v, 32'h0);
        chk("R3 reset live_div", 32'(live_div), 32'h0);

        // R1 field positions and masks
        wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, v); chk("R1 cfg mask", v, 32'h0000_371F);
        wr(A_CFG, 32'h0000_2305); rd(A_CFG, v); chk("R1 cfg readback", v, 32'h0000_2305);
        rd(A_CMD, v); chk("R2 dirty cfg bit4", v, 32'h8000_0010);
        wr(A_M, 32'hABCD_EF12); rd(A_M, v); chk("R1 M masked", v, 32'h12);
        rd(A_CMD, v); chk("R2 dirty M bit6", v, 32'h8000_0050);
        wr(A_N, 32'h34); rd(A_N, v); chk("R1 N readback", v, 32'h34);
        rd(A_CMD, v); chk("R2 dirty N bit5", v, 32'h8000_0070);
        wr(A_D, 32'h56); rd(A_D, v); chk("R1 D readback", v, 32'h56);
        rd(A_CMD, v); chk("R2 dirty D bit7", v, 32'h8000_00F0);
        rd(5'h14, v); chk("R1 unmapped reads 0", v, 32'h0);

        // R3 no live change before update
        repeat (50) @(negedge clk);
        chk("R3 live_div held", 32'(live_div), 32'h0);
        chk("R3 live_m held", 32'(live_m), 32'h0);

        // R3/R4 update with enable
        wr(A_CMD, 32'h3);
        rd(A_CMD, v); chk("R3 update bit set", 32'(v[0]), 32'h1);
        chk("R11 enable readback", 32'(v[1]), 32'h1);
        wait_idle("R4 update cleared");
        chk("R4 live_div", 32'(live_div), 32'd5);
        chk("R4 live_sel", 32'(live_sel), 32'd3);
        chk("R4 live_mode", 32'(live_mode), 32'd2);
        chk("R4 live_m", 32'(live_m), 32'h12);
        chk("R4 live_n", 32'(live_n), 32'h34);
        chk("R4 live_d", 32'(live_d), 32'h56);
        rd(A_CMD, v); chk("R5 R7 cmd after update", v, 32'h0000_0002);

        // R7 source stopped
        src_run = 8'hF7; #1;
        chk("R7 root_off port src stopped", 32'(root_off), 32'h1);
        rd(A_CMD, v); chk("R7 cmd bit31 src stopped", 32'(v[31]), 32'h1);
        src_run = 8'hFF; #1;
        chk("R7 root_off port running", 32'(root_off), 32'h0);

        // R5/R6 writes during a pending update
        wr(A_CFG, 32'h0000_0104);
        wr(A_CMD, 32'h3);
        wr(A_CFG, 32'h0000_0207);
        wr(A_M, 32'h77);
        wait_idle("R4 second update cleared");
        chk("R6 live_div first snapshot", 32'(live_div), 32'd4);
        chk("R6 live_sel first snapshot", 32'(live_sel), 32'd1);
        chk("R6 live_m first snapshot", 32'(live_m), 32'h12);
        rd(A_CMD, v); chk("R5 late dirty survives", v, 32'h0000_0052);
        wr(A_CMD, 32'h3);
        wait_idle("R4 third update cleared");
        chk("R6 live_div next update", 32'(live_div), 32'd7);
        chk("R6 live_m next update", 32'(live_m), 32'h77);
        rd(A_CMD, v); chk("R5 dirty cleared", v, 32'h0000_0002);

        // R8 sweep every divide field
        for (int dv = 0; dv < (1 << HIDW); dv++) begin
            int hp;
            hp = (dv == 0) ? 2 : dv + 1;
            wr(A_CFG, 32'(dv));
            wr(A_CMD, 32'h3);
            wait_idle("R4 sweep update cleared");
            measure(per, hi);
            chk_t($sformatf("R8 period div=%0d", dv), per, hp * HALF);
            chk_t($sformatf("R8 high div=%0d", dv), hi, (hp / 2) * HALF);
        end

        // R10 disable stops clock low
        wr(A_CMD, 32'h0);
        repeat (200) @(negedge clk);
        hcnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #0.5;
            if (clk_out) hcnt++;
        end
        chk("R10 clock held low when disabled", 32'(hcnt), 32'h0);

        // R4 commit while disabled, R10 resume
        wr(A_CFG, 32'h3);
        wr(A_CMD, 32'h1);
        wait_idle("R4 update while disabled");
        chk("R4 live_div while disabled", 32'(live_div), 32'd3);
        chk("R10 still low", 32'(clk_out), 32'h0);
        wr(A_CMD, 32'h2);
        measure(per, hi);
        chk_t("R10 resumed period", per, 4 * HALF);
        chk_t("R10 resumed high", hi, 2 * HALF);

        finish_run();
    end
endmodule